// File: doc/BRIEF.md
# Dispatch Admission Gate with Bandwidth Carry-Over

This block sits at the dispatch stage of an out-of-order core. Each clock it looks at one candidate instruction and decides whether to admit it. The instruction is described by its micro-op count, its number of destination register writes, and whether it needs a load or a store queue entry. The reorder buffer, the rename pool and the scheduler queues are outside the block. They report their free space, or a room flag, on input pins. The gate raises `in_ready` only when every check passes. An instruction is dispatched on a clock where `in_valid` and `in_ready` are both high.

Every clock is one dispatch cycle with `DISP_W` micro-op entries. An instruction wider than what is left may still go if the cycle is untouched, meaning the bandwidth left equals the full width. Its excess micro-ops go into a carry-over counter. That counter takes bandwidth from the cycles that follow. When an instruction is refused, the gate records one cause. The cause is the first check that fails in a fixed priority order, and it increments a saturating counter kept per cause.

Top module: `dispatch_gate`

## Requirements
- R1: The bandwidth check passes when `in_uops` <= `bw_avail`, or when `bw_avail` equals `DISP_W`. A zero micro-op instruction always passes this check.
- R2: On each clock edge, an accepted instruction whose `in_uops` exceeds `bw_avail` adds the difference to the carry-over. Then `bw_avail` becomes `DISP_W` minus the carry-over, floored at 0. The carry-over is then lowered by `DISP_W`, floored at 0. Without acceptance, only the second step happens.
- R3: The reorder buffer check passes when min(`in_uops`, `ROB_SLOTS`) <= `rob_free`.
- R4: The rename check passes when `in_writes` <= `ren_free`. With `RENAME_REGS` = 0 the pool is unlimited and this check always passes.
- R5: The scheduler check needs `sq_room` = 1. The load check needs `lq_room` = 1 only when `in_is_load` = 1. The store check needs `stq_room` = 1 only when `in_is_store` = 1.
- R6: `in_ready` is high exactly when all checks of R1, R3, R4 and R5 pass. An instruction is accepted on a clock where `in_valid` and `in_ready` are both high.
- R7: When `in_valid` = 1 and `in_ready` = 0, exactly one stall counter increments: that of the first failing check. The priority order and field index are: bandwidth 0, reorder buffer 1, rename 2, scheduler 3, load queue 4, store queue 5. Field i is `stall_cnt[i*CNT_W +: CNT_W]`.
- R8: No stall counter changes on a clock where `in_valid` = 0 or where an instruction is accepted.
- R9: A stall counter at its all-ones value stays there.
- R10: While `rst_n` = 0, `bw_avail` equals `DISP_W`, all stall counters are zero and the carry-over is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Candidate instruction present |
| in_uops | input | UOP_W | Micro-op count of the candidate |
| in_writes | input | WR_W | Destination registers to rename |
| in_is_load | input | 1 | Candidate needs a load queue entry |
| in_is_store | input | 1 | Candidate needs a store queue entry |
| rob_free | input | FREE_W | Free reorder buffer slots |
| ren_free | input | FREE_W | Free rename temporaries |
| sq_room | input | 1 | Scheduler queue has an entry free |
| lq_room | input | 1 | Load queue has an entry free |
| stq_room | input | 1 | Store queue has an entry free |
| in_ready | output | 1 | All admission checks pass |
| bw_avail | output | clog2(DISP_W+1) | Dispatch entries left in this cycle |
| stall_cnt | output | 6*CNT_W | Saturating stall counters, field per cause |

## Verification
`in_ready` depends only on the present inputs and the present bandwidth state, so it is due in the same cycle as the stimulus. The bench samples it 1 ns after the falling edge on which the inputs were driven. `bw_avail` and the stall counters are registered and take effect on the next rising edge. The bench model therefore advances its own bandwidth, carry-over and counter values only after comparing the current cycle. It then compares the updated values at the next sample point, one clock after the stimulus. A second instance with an unlimited rename pool receives the same inputs and is tracked by its own model state.

// File: rtl/dg_pkg.sv
package dg_pkg;
   typedef enum logic [2:0] {
      ST_GROUP = 3'd0,
      ST_ROB   = 3'd1,
      ST_REN   = 3'd2,
      ST_SQ    = 3'd3,
      ST_LDQ   = 3'd4,
      ST_STQ   = 3'd5
   } stall_e;

   localparam int NUM_STALL = 6;
endpackage

// File: rtl/dg_bandwidth.sv
module dg_bandwidth #(
   parameter int DISP_W = 4,
   parameter int UOP_W  = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             fire,
   input  logic [UOP_W-1:0]                 uops,
   output logic [$clog2(DISP_W+1)-1:0]      avail
);
   localparam int AV_W = $clog2(DISP_W + 1);
   localparam int CW   = UOP_W + 1;

   logic [AV_W-1:0] avail_q;
   logic [CW-1:0]   carry_q;
   logic [CW-1:0]   excess;
   logic [CW-1:0]   carry_mid;

   always_comb begin
      excess = '0;
      if (fire && (CW'(uops) > CW'(avail_q)))
         excess = CW'(uops) - CW'(avail_q);
      carry_mid = carry_q + excess;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avail_q <= AV_W'(DISP_W);
         carry_q <= '0;
      end else if (carry_mid >= CW'(DISP_W)) begin
         avail_q <= '0;
         carry_q <= carry_mid - CW'(DISP_W);
      end else begin
         avail_q <= AV_W'(CW'(DISP_W) - carry_mid);
         carry_q <= '0;
      end
   end

   assign avail = avail_q;
endmodule

// File: rtl/dg_resource_check.sv
module dg_resource_check import dg_pkg::*; #(
   parameter int DISP_W      = 4,
   parameter int UOP_W       = 4,
   parameter int WR_W        = 3,
   parameter int FREE_W      = 6,
   parameter int ROB_SLOTS   = 32,
   parameter int RENAME_REGS = 16
) (
   input  logic [UOP_W-1:0]              uops,
   input  logic [WR_W-1:0]               writes,
   input  logic                          is_load,
   input  logic                          is_store,
   input  logic [$clog2(DISP_W+1)-1:0]   avail,
   input  logic [FREE_W-1:0]             rob_free,
   input  logic [FREE_W-1:0]             ren_free,
   input  logic                          sq_room,
   input  logic                          lq_room,
   input  logic                          stq_room,
   output logic                          pass,
   output logic [NUM_STALL-1:0]          cause_oh
);
   logic [31:0]          u32;
   logic [31:0]          rob_need;
   logic                 ren_ok;
   logic [NUM_STALL-1:0] fail;

   assign u32      = 32'(uops);
   assign rob_need = (u32 > 32'(ROB_SLOTS)) ? 32'(ROB_SLOTS) : u32;

   generate
      if (RENAME_REGS == 0) begin : g_ren_unlimited
         logic unused_ren;
         assign unused_ren = ^{writes, ren_free};
         assign ren_ok     = 1'b1;
      end else begin : g_ren_limited
         assign ren_ok = (32'(writes) <= 32'(ren_free));
      end
   endgenerate

   always_comb begin
      fail           = '0;
      fail[ST_GROUP] = !((u32 <= 32'(avail)) || (32'(avail) == 32'(DISP_W)));
      fail[ST_ROB]   = rob_need > 32'(rob_free);
      fail[ST_REN]   = !ren_ok;
      fail[ST_SQ]    = !sq_room;
      fail[ST_LDQ]   = is_load && !lq_room;
      fail[ST_STQ]   = is_store && !stq_room;
   end

   generate
      for (genvar i = 0; i < NUM_STALL; i++) begin : g_prio
         if (i == 0) begin : g_top
            assign cause_oh[i] = fail[i];
         end else begin : g_rest
            assign cause_oh[i] = fail[i] && !(|fail[i-1:0]);
         end
      end
   endgenerate

   assign pass = !(|fail);
endmodule

// File: rtl/dg_stall_counters.sv
module dg_stall_counters #(
   parameter int N     = 6,
   parameter int CNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N-1:0]       inc,
   output logic [N*CNT_W-1:0] counts
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (inc[i] && (cnt_q != {CNT_W{1'b1}}))
               cnt_q <= cnt_q + 1'b1;
         end
         assign counts[i*CNT_W +: CNT_W] = cnt_q;
      end
   endgenerate
endmodule

// File: rtl/dispatch_gate.sv
module dispatch_gate import dg_pkg::*; #(
   parameter int DISP_W      = 4,
   parameter int UOP_W       = 4,
   parameter int WR_W        = 3,
   parameter int FREE_W      = 6,
   parameter int ROB_SLOTS   = 32,
   parameter int RENAME_REGS = 16,
   parameter int CNT_W       = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [UOP_W-1:0]              in_uops,
   input  logic [WR_W-1:0]               in_writes,
   input  logic                          in_is_load,
   input  logic                          in_is_store,
   input  logic [FREE_W-1:0]             rob_free,
   input  logic [FREE_W-1:0]             ren_free,
   input  logic                          sq_room,
   input  logic                          lq_room,
   input  logic                          stq_room,
   output logic                          in_ready,
   output logic [$clog2(DISP_W+1)-1:0]   bw_avail,
   output logic [NUM_STALL*CNT_W-1:0]    stall_cnt
);
   generate
      if (DISP_W < 1) begin : g_bad_width
         $error("DISP_W must be at least 1");
      end
      if (DISP_W > (1 << UOP_W) - 1) begin : g_bad_uop
         $error("UOP_W too narrow for DISP_W");
      end
      if (ROB_SLOTS < 1 || ROB_SLOTS > (1 << FREE_W) - 1) begin : g_bad_rob
         $error("ROB_SLOTS out of range for FREE_W");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic                 pass;
   logic                 fire;
   logic [NUM_STALL-1:0] cause_oh;

   dg_bandwidth #(.DISP_W(DISP_W), .UOP_W(UOP_W)) u_bw (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .uops  (in_uops),
      .avail (bw_avail)
   );

   dg_resource_check #(
      .DISP_W(DISP_W), .UOP_W(UOP_W), .WR_W(WR_W), .FREE_W(FREE_W),
      .ROB_SLOTS(ROB_SLOTS), .RENAME_REGS(RENAME_REGS)
   ) u_res (
      .uops     (in_uops),
      .writes   (in_writes),
      .is_load  (in_is_load),
      .is_store (in_is_store),
      .avail    (bw_avail),
      .rob_free (rob_free),
      .ren_free (ren_free),
      .sq_room  (sq_room),
      .lq_room  (lq_room),
      .stq_room (stq_room),
      .pass     (pass),
      .cause_oh (cause_oh)
   );

   dg_stall_counters #(.N(NUM_STALL), .CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (cause_oh & {NUM_STALL{in_valid}}),
      .counts (stall_cnt)
   );

   assign in_ready = pass;
   assign fire     = in_valid && pass;
endmodule

// File: rtl/dispatch_gate_chk.sv
module dispatch_gate_chk import dg_pkg::*; #(
   parameter int DISP_W    = 4,
   parameter int UOP_W     = 4,
   parameter int FREE_W    = 6,
   parameter int ROB_SLOTS = 32,
   parameter int CNT_W     = 16
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          in_valid,
   input logic                          in_ready,
   input logic [UOP_W-1:0]              in_uops,
   input logic [FREE_W-1:0]             rob_free,
   input logic                          sq_room,
   input logic [$clog2(DISP_W+1)-1:0]   bw_avail,
   input logic [NUM_STALL*CNT_W-1:0]    stall_cnt
);
   logic                       past_ok;
   logic                       quiet_q;
   logic [NUM_STALL*CNT_W-1:0] prev_cnt;
   logic [NUM_STALL-1:0]       chg;
   logic [31:0]                cap_need;
   logic                       over_bw;

   assign cap_need = (32'(in_uops) > 32'(ROB_SLOTS)) ? 32'(ROB_SLOTS) : 32'(in_uops);
   assign over_bw  = 32'(in_uops) > 32'(bw_avail);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         past_ok  <= 1'b0;
         quiet_q  <= 1'b1;
         prev_cnt <= '0;
      end else begin
         past_ok  <= 1'b1;
         quiet_q  <= !(in_valid && !in_ready);
         prev_cnt <= stall_cnt;
      end
   end

   generate
      for (genvar i = 0; i < NUM_STALL; i++) begin : g_chg
         assign chg[i] = stall_cnt[i*CNT_W +: CNT_W] != prev_cnt[i*CNT_W +: CNT_W];

         AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && (prev_cnt[i*CNT_W +: CNT_W] == {CNT_W{1'b1}}))
            |-> (stall_cnt[i*CNT_W +: CNT_W] == {CNT_W{1'b1}})); // R9
      end
   endgenerate

   AST_WIDE_NEEDS_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && over_bw) |-> (32'(bw_avail) == 32'(DISP_W))); // R1

   AST_BW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(bw_avail) <= 32'(DISP_W)); // R2

   AST_CARRY_TAKES_BW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && over_bw) |=> (32'(bw_avail) < 32'(DISP_W))); // R2

   AST_FRESH_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      ((32'(bw_avail) == 32'(DISP_W)) && !(in_valid && in_ready))
      |=> (32'(bw_avail) == 32'(DISP_W))); // R2

   AST_ROB_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (cap_need <= 32'(rob_free))); // R3

   AST_SCHED_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> sq_room); // R5

   AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ($countones(chg) <= 1)); // R7

   AST_QUIET_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && quiet_q) |-> (chg == '0)); // R8
endmodule

bind dispatch_gate dispatch_gate_chk #(
   .DISP_W(DISP_W), .UOP_W(UOP_W), .FREE_W(FREE_W),
   .ROB_SLOTS(ROB_SLOTS), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/dispatch_gate_tb.sv
module dispatch_gate_tb;
   localparam int TW  = 4;
   localparam int UW  = 4;
   localparam int WW  = 3;
   localparam int FW  = 6;
   localparam int ROB = 12;
   localparam int REN = 8;
   localparam int CW  = 4;
   localparam int AW  = $clog2(TW + 1);
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n;
   logic in_valid, in_is_load, in_is_store, sq_room, lq_room, stq_room;
   logic [UW-1:0] in_uops;
   logic [WW-1:0] in_writes;
   logic [FW-1:0] rob_free, ren_free;
   logic rdy0, rdy1;
   logic [AW-1:0] bw0, bw1;
   logic [6*CW-1:0] cnt0, cnt1;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   int m_av [2];
   int m_cy [2];
   int m_cnt [2][6];

   always #4 clk = ~clk;

   dispatch_gate #(.DISP_W(TW), .UOP_W(UW), .WR_W(WW), .FREE_W(FW),
      .ROB_SLOTS(ROB), .RENAME_REGS(REN), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
      .in_writes(in_writes), .in_is_load(in_is_load), .in_is_store(in_is_store),
      .rob_free(rob_free), .ren_free(ren_free), .sq_room(sq_room),
      .lq_room(lq_room), .stq_room(stq_room), .in_ready(rdy0),
      .bw_avail(bw0), .stall_cnt(cnt0));

   dispatch_gate #(.DISP_W(TW), .UOP_W(UW), .WR_W(WW), .FREE_W(FW),
      .ROB_SLOTS(ROB), .RENAME_REGS(0), .CNT_W(CW)) u_unl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
      .in_writes(in_writes), .in_is_load(in_is_load), .in_is_store(in_is_store),
      .rob_free(rob_free), .ren_free(ren_free), .sq_room(sq_room),
      .lq_room(lq_room), .stq_room(stq_room), .in_ready(rdy1),
      .bw_avail(bw1), .stall_cnt(cnt1));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int first_fail(input int v);
      int u = int'(in_uops);
      int need = (u > ROB) ? ROB : u;
      if (!(u <= m_av[v] || m_av[v] == TW)) return 0;
      if (need > int'(rob_free)) return 1;
      if (v == 0 && int'(in_writes) > int'(ren_free)) return 2;
      if (!sq_room) return 3;
      if (in_is_load && !lq_room) return 4;
      if (in_is_store && !stq_room) return 5;
      return -1;
   endfunction

   function automatic string tag_of(input int ff);
      case (ff)
         -1: return "R6 ready";
         0: return "R1 bandwidth";
         1: return "R3 reorder buffer";
         2: return "R4 rename";
         default: return "R5 queue";
      endcase
   endfunction

   function automatic int field(input int v, input int k);
      return (v == 0) ? int'(cnt0[k*CW +: CW]) : int'(cnt1[k*CW +: CW]);
   endfunction

   task automatic step();
      #1;
      for (int v = 0; v < 2; v++) begin
         int ff = first_fail(v);
         int rdy = (v == 0) ? int'(rdy0) : int'(rdy1);
         int bw = (v == 0) ? int'(bw0) : int'(bw1);
         chk(rdy == (ff < 0 ? 1 : 0), tag_of(ff), rdy, ff < 0 ? 1 : 0);
         chk(bw == m_av[v], "R2 bw_avail", bw, m_av[v]);
         for (int k = 0; k < 6; k++)
            chk(field(v, k) == m_cnt[v][k], "R7 stall counter", field(v, k), m_cnt[v][k]);
         if (in_valid && ff < 0 && int'(in_uops) > m_av[v])
            m_cy[v] += int'(in_uops) - m_av[v];
         if (in_valid && ff >= 0 && m_cnt[v][ff] < CMAX)
            m_cnt[v][ff]++;
         if (m_cy[v] >= TW) begin
            m_av[v] = 0;
            m_cy[v] -= TW;
         end else begin
            m_av[v] = TW - m_cy[v];
            m_cy[v] = 0;
         end
      end
      @(negedge clk);
   endtask

   task automatic set_ok(input int u);
      in_valid = 1'b1; in_uops = UW'(u); in_writes = '0;
      in_is_load = 1'b0; in_is_store = 1'b0;
      rob_free = FW'(63); ren_free = FW'(63);
      sq_room = 1'b1; lq_room = 1'b1; stq_room = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd7321);
      rst_n = 1'b0;
      set_ok(0);
      in_valid = 1'b0;
      for (int v = 0; v < 2; v++) begin
         m_av[v] = TW; m_cy[v] = 0;
         for (int k = 0; k < 6; k++) m_cnt[v][k] = 0;
      end
      repeat (3) @(negedge clk);
      #1;
      chk(int'(bw0) == TW, "R10 reset bw_avail", int'(bw0), TW);
      chk(cnt0 == '0, "R10 reset counters", int'(cnt0), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // oversized instruction and carry-over (R1, R2)
      set_ok(10); step();
      #1 chk(int'(bw0) == 0, "R2 carry empties next cycle", int'(bw0), 0);
      set_ok(1); step();
      #1 chk(int'(bw0) == 2, "R2 carry remainder", int'(bw0), 2);
      chk(int'(cnt0[0 +: CW]) == 1, "R1 group stall counted", int'(cnt0[0 +: CW]), 1);
      set_ok(3); step();
      set_ok(2); step();
      #1 chk(int'(bw0) == TW, "R2 bandwidth restored", int'(bw0), TW);

      // reorder buffer cap (R3)
      set_ok(14); rob_free = FW'(ROB); step();
      // idle with failing resources (R8)
      for (int i = 0; i < 3; i++) begin
         set_ok(3); in_valid = 1'b0; sq_room = 1'b0; rob_free = '0; step();
      end
      #1 chk(int'(cnt0[1*CW +: CW]) == 0 && int'(cnt0[3*CW +: CW]) == 0,
             "R8 idle no count", int'(cnt0[3*CW +: CW]), 0);

      // priority order (R7)
      set_ok(3); rob_free = '0; in_writes = 3'd7; ren_free = '0; sq_room = 1'b0;
      in_is_load = 1'b1; lq_room = 1'b0; step();
      rob_free = FW'(20); step();
      ren_free = FW'(10); step();
      #1 chk(rdy1 == 1'b0 && int'(cnt1[2*CW +: CW]) == 0, "R4 unlimited never rename",
             int'(cnt1[2*CW +: CW]), 0);
      sq_room = 1'b1; step();
      lq_room = 1'b1; in_is_store = 1'b1; stq_room = 1'b0; step();

      // unlimited rename pool (R4)
      set_ok(1); in_writes = 3'd7; ren_free = '0;
      #1 chk(rdy0 == 1'b0 && rdy1 == 1'b1, "R4 limit zero bypass", int'(rdy1), 1);
      step();

      // saturation (R9)
      set_ok(1); sq_room = 1'b0;
      for (int i = 0; i < 20; i++) step();
      #1 chk(int'(cnt0[3*CW +: CW]) == CMAX, "R9 saturated", int'(cnt0[3*CW +: CW]), CMAX);

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         in_valid    = ($urandom_range(0, 9) < 8);
         in_uops     = ($urandom_range(0, 9) < 7) ? UW'($urandom_range(0, 4))
                                                : UW'($urandom_range(5, 15));
         in_writes   = WW'($urandom_range(0, 7));
         in_is_load  = ($urandom_range(0, 9) < 3);
         in_is_store = ($urandom_range(0, 9) < 3);
         rob_free    = FW'($urandom_range(0, 20));
         ren_free    = FW'($urandom_range(0, 10));
         sq_room     = ($urandom_range(0, 19) < 17);
         lq_room     = ($urandom_range(0, 19) < 17);
         stq_room    = ($urandom_range(0, 19) < 17);
         step();
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule